// File: doc/BRIEF.md
# Core-Voltage Regulator Start-Up Sequencer

This block orders the power-up of a multiphase core-voltage regulator. Once supply power-on reset is released, it waits a fixed delay. It then waits for the enable input. After that it slews a digital DAC setpoint upward at a controlled rate. A window-comparator result is qualified against a count of PWM switching cycles. The block then pulls an active-low clock-enable output low and, after a fixed time from the start of the ramp, raises power-good.

In CPU configuration the ramp has two phases. The setpoint first climbs slowly to a 1.1 V boot level and waits there for qualification. It then moves at twice that rate to the voltage commanded by the 7-bit VID code. In GPU configuration the ramp goes straight to the VID voltage. Its rate doubles when the low-power select is high. After start-up, a new VID code moves the setpoint toward the new target at the active rate. Dropping the enable or losing power-on reset returns the block to idle at once.

The setpoint is carried in 0.5 mV units: 1.5 V is 3000 and 1.1 V is 2200. Slew steps are applied once per microsecond, on a tick divided down from the system clock.

Top module: `vrs_startup_seq`

## Requirements
- R1: The DAC code stays 0 while `vr_en` is low. A ramp begins only when `por_ok` has been high for `EN_DELAY_US` microsecond ticks and `vr_en` is high.
- R2: In CPU mode (`gpu_mode`=0) the first ramp rises by 5 units (2.5 mV) per microsecond tick. It stops exactly at the boot code 2200 and stays there until qualification.
- R3: `clk_en_n` stays high until 13 consecutive `pwm_pulse` cycles with `in_win`=1 have been seen after the ramp target was reached. It goes low in the cycle after the 13th.
- R4: A `pwm_pulse` with `in_win`=0 clears the qualification count to zero.
- R5: In CPU mode, after `clk_en_n` falls, the DAC code moves from 2200 to the VID target by 10 units per tick and never passes it.
- R6: In GPU mode the DAC code ramps directly to the VID target without stopping at 2200. The step is 10 units per tick with `lp_sel`=0 and 20 with `lp_sel`=1.
- R7: The VID target code is 3000 − 25×`vid`, or 0 when that would be negative (`vid` ≥ 120).
- R8: `pwr_good` rises only in the run state, `PG_DELAY_US` ticks after the ramp began, and only while `clk_en_n` is low.
- R9: After start-up, a change of `vid` moves the DAC code toward the new target, up or down, at the active mode's step.
- R10: When `vr_en` or `por_ok` is low at a clock edge, `dac_code` is 0, `clk_en_n` is 1 and `pwr_good` is 0 after that edge. These are also the reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Supply is above its power-on-reset threshold |
| vr_en | input | 1 | Regulator enable |
| vid | input | 7 | Voltage identification code |
| lp_sel | input | 1 | Low-power select, doubles the GPU slew |
| gpu_mode | input | 1 | 0 = CPU configuration, 1 = GPU configuration |
| in_win | input | 1 | Output voltage is within 10% of the target |
| pwm_pulse | input | 1 | One-cycle pulse per PWM switching cycle |
| dac_code | output | 12 | DAC setpoint in 0.5 mV units |
| clk_en_n | output | 1 | Active-low clock enable |
| pwr_good | output | 1 | Power-good |

## Verification
A wrong sequencer state shows at the ports within one clock. A wrong state misdrives `clk_en_n` or `pwr_good` directly, or the DAC code takes a step of the wrong size on the next microsecond tick. A corrupt qualification count shows as a clock-enable edge one PWM pulse early or late. A wrong slew step appears as a wrong increment at the first tick of a ramp, and a bad clamp appears as a final code past the target. The directed scenarios therefore watch every DAC change and count the pulses before the clock-enable edge.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int unsigned DAC_W = 12;
  typedef logic [DAC_W-1:0] hmv_t;

  localparam int unsigned BOOT_HMV  = 2200;
  localparam int unsigned TOP_HMV   = 3000;
  localparam int unsigned VID_LSB   = 25;
  localparam int unsigned STEP_BOOT = 5;
  localparam int unsigned STEP_NORM = 10;
  localparam int unsigned STEP_FAST = 20;

  typedef enum logic [2:0] {
    S_IDLE, S_DLY, S_ARM, S_RAMP1, S_QUAL, S_SLEW2, S_RUN
  } seq_state_e;

  function automatic hmv_t vid_to_hmv(input logic [6:0] code);
    int unsigned drop;
    drop = int'(code) * VID_LSB;
    if (drop >= TOP_HMV) return '0;
    return hmv_t'(TOP_HMV - drop);
  endfunction

  function automatic hmv_t step_for(input logic boot_phase, input logic gpu, input logic lp);
    if (boot_phase) return hmv_t'(STEP_BOOT);
    if (gpu && lp)  return hmv_t'(STEP_FAST);
    return hmv_t'(STEP_NORM);
  endfunction

  function automatic hmv_t slew_toward(input hmv_t cur, input hmv_t tgt, input hmv_t step);
    if (cur < tgt) return ((tgt - cur) > step) ? cur + step : tgt;
    if (cur > tgt) return ((cur - tgt) > step) ? cur - step : tgt;
    return cur;
  endfunction
endpackage

// File: rtl/vrs_tick.sv
module vrs_tick #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/vrs_us_timer.sv
module vrs_us_timer #(
  parameter int unsigned LIMIT = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (tick && !done)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vrs_qual.sv
module vrs_qual #(
  parameter int unsigned CYCLES = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pwm_pulse,
  input  logic in_win,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = arm && pwm_pulse && in_win && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!arm)       cnt <= '0;
    else if (pwm_pulse)  cnt <= in_win ? ((cnt == CW'(CYCLES)) ? cnt : cnt + 1'b1) : '0;
  end
endmodule

// File: rtl/vrs_startup_seq.sv
module vrs_startup_seq #(
  parameter int unsigned CLK_PER_US  = 250,
  parameter int unsigned EN_DELAY_US = 120,
  parameter int unsigned PG_DELAY_US = 7000,
  parameter int unsigned QUAL_CYCLES = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_ok,
  input  logic        vr_en,
  input  logic [6:0]  vid,
  input  logic        lp_sel,
  input  logic        gpu_mode,
  input  logic        in_win,
  input  logic        pwm_pulse,
  output logic [11:0] dac_code,
  output logic        clk_en_n,
  output logic        pwr_good
);
  import vrs_pkg::*;

  seq_state_e state, state_nx;
  hmv_t dac_q, target, step;
  logic us_tick, dly_done, pg_done, qual_done;
  logic ramping, boot_phase, at_tgt, abort;

  vrs_tick #(.DIV(CLK_PER_US)) u_tick (.clk(clk), .rst_n(rst_n), .tick(us_tick));

  vrs_us_timer #(.LIMIT(EN_DELAY_US)) u_dly (
    .clk(clk), .rst_n(rst_n), .run(state == S_DLY), .tick(us_tick), .done(dly_done));

  vrs_us_timer #(.LIMIT(PG_DELAY_US)) u_pg (
    .clk(clk), .rst_n(rst_n), .run(ramping), .tick(us_tick), .done(pg_done));

  vrs_qual #(.CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .arm(state == S_QUAL), .pwm_pulse(pwm_pulse),
    .in_win(in_win), .done(qual_done));

  assign abort      = !por_ok || !vr_en;
  assign ramping    = (state == S_RAMP1) || (state == S_QUAL) ||
                      (state == S_SLEW2) || (state == S_RUN);
  assign boot_phase = !gpu_mode && ((state == S_RAMP1) || (state == S_QUAL));
  assign target     = boot_phase ? hmv_t'(BOOT_HMV) : vid_to_hmv(vid);
  assign step       = step_for(boot_phase, gpu_mode, lp_sel);
  assign at_tgt     = (dac_q == target);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (por_ok) state_nx = S_DLY;
      S_DLY:   if (dly_done) state_nx = S_ARM;
      S_ARM:   if (vr_en) state_nx = S_RAMP1;
      S_RAMP1: if (at_tgt) state_nx = S_QUAL;
      S_QUAL:  if (qual_done) state_nx = gpu_mode ? S_RUN : S_SLEW2;
      S_SLEW2: if (at_tgt) state_nx = S_RUN;
      S_RUN:   state_nx = S_RUN;
      default: state_nx = S_IDLE;
    endcase
    if (!por_ok) state_nx = S_IDLE;
    else if (!vr_en && ramping) state_nx = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      dac_q <= '0;
    end else begin
      state <= state_nx;
      if (abort || !ramping) dac_q <= '0;
      else if (us_tick)      dac_q <= slew_toward(dac_q, target, step);
    end
  end

  assign dac_code = dac_q;
  assign clk_en_n = !((state == S_SLEW2) || (state == S_RUN));
  assign pwr_good = (state == S_RUN) && pg_done;
endmodule

// File: rtl/vrs_startup_chk.sv
module vrs_startup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        por_ok,
  input logic        vr_en,
  input logic [11:0] dac_code,
  input logic        clk_en_n,
  input logic        pwr_good,
  input logic        qual_done,
  input logic        boot_phase
);
  logic [11:0] prev_dac;
  logic        step_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_dac <= '0;
    else        prev_dac <= dac_code;
  end

  assign step_ok = (dac_code == 12'd0) ||
                   ((dac_code >= prev_dac) ? (dac_code - prev_dac <= 12'd20)
                                           : (prev_dac - dac_code <= 12'd20));

  AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !vr_en) |=> (dac_code == 12'd0 && clk_en_n && !pwr_good)); // R10

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok); // R6

  AST_BOOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    boot_phase |-> (dac_code <= 12'd2200)); // R2

  AST_CKEN_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_n) |-> $past(qual_done)); // R3

  AST_PG_CKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> !clk_en_n); // R8
endmodule

bind vrs_startup_seq vrs_startup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .vr_en(vr_en),
  .dac_code(dac_code), .clk_en_n(clk_en_n), .pwr_good(pwr_good),
  .qual_done(qual_done), .boot_phase(boot_phase));

// File: tb/tb_vrs_startup_seq.sv
module tb_vrs_startup_seq;
  localparam int CPU  = 4;
  localparam int DLY  = 10;
  localparam int PGD  = 600;

  logic clk = 0, rst_n = 0;
  logic por_ok = 0, vr_en = 0, lp_sel = 0, gpu_mode = 0, in_win = 0, pwm_pulse = 0;
  logic [6:0] vid = 0;
  logic [11:0] dac_code;
  logic clk_en_n, pwr_good;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vrs_startup_seq #(.CLK_PER_US(CPU), .EN_DELAY_US(DLY), .PG_DELAY_US(PGD), .QUAL_CYCLES(13)) dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .vr_en(vr_en), .vid(vid), .lp_sel(lp_sel),
    .gpu_mode(gpu_mode), .in_win(in_win), .pwm_pulse(pwm_pulse),
    .dac_code(dac_code), .clk_en_n(clk_en_n), .pwr_good(pwr_good));

  function automatic int exp_vid(input int code);
    return (code * 25 >= 3000) ? 0 : 3000 - code * 25;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit win);
    @(negedge clk); pwm_pulse = 1; in_win = win;
    @(negedge clk); pwm_pulse = 0;
    nclk(1);
  endtask

  // Follows the DAC to 'fin', counting steps whose size differs from 'stp'
  task automatic ramp_to(input int fin, input int stp, input int tmo, input string req,
                         output longint first_chg);
    int prev, bad, over, d;
    bool_loop: begin end
    prev = dac_code; bad = 0; over = 0; first_chg = -1;
    for (int i = 0; i < tmo && dac_code != fin; i++) begin
      @(negedge clk);
      if (dac_code != prev) begin
        if (first_chg < 0) first_chg = cyc;
        d = (dac_code > prev) ? dac_code - prev : prev - dac_code;
        if (d != stp && dac_code != fin) bad++;
        if (prev < fin && dac_code > fin) over++;
        if (prev > fin && dac_code < fin) over++;
        prev = dac_code;
      end
    end
    check(dac_code == fin, {req, " final code"}, dac_code, fin);
    check(bad == 0 && over == 0, {req, " step size/overshoot"}, bad + over, 0);
  endtask

  task automatic t_reset();
    check(dac_code == 0 && clk_en_n == 1 && pwr_good == 0, "R10 reset state",
          {dac_code, clk_en_n, pwr_good}, 2);
  endtask

  task automatic t_en_gate();
    por_ok = 1; vr_en = 0;
    nclk(100 * CPU);
    check(dac_code == 0 && clk_en_n == 1, "R1 no ramp while enable low", dac_code, 0);
    por_ok = 0; nclk(3);
  endtask

  task automatic t_cpu();
    longint t0, t1, tr, tpg;
    gpu_mode = 0; lp_sel = 0; vid = 7'd8; vr_en = 1;
    @(negedge clk); por_ok = 1; t0 = cyc;
    while (dac_code == 0 && cyc - t0 < 200) @(negedge clk);
    t1 = cyc;
    check(t1 - t0 >= DLY * CPU - 2 && t1 - t0 <= DLY * CPU + 12, "R1 ramp after POR delay",
          t1 - t0, DLY * CPU);
    ramp_to(2200, 5, 2500, "R2 boot ramp", tr);
    tr = t1;
    nclk(40);
    check(dac_code == 2200 && clk_en_n == 1, "R2 boot hold", dac_code, 2200);
    for (int i = 0; i < 8; i++) pulse(1);
    pulse(0);
    for (int i = 0; i < 12; i++) pulse(1);
    check(clk_en_n == 1, "R4 out-of-window pulse restarts count", clk_en_n, 1);
    pulse(1);
    check(clk_en_n == 0, "R3 clock enable after 13 cycles", clk_en_n, 0);
    ramp_to(exp_vid(8), 10, 600, "R5 second ramp", t1);
    check(pwr_good == 0, "R8 no power-good before delay", pwr_good, 0);
    while (!pwr_good && cyc - tr < 4000) @(negedge clk);
    tpg = cyc;
    check(tpg - tr >= PGD * CPU - 10 && tpg - tr <= PGD * CPU + 4, "R8 power-good timing",
          tpg - tr, PGD * CPU);
    vid = 7'd24;
    ramp_to(exp_vid(24), 10, 400, "R9 VID change down", t1);
    check(pwr_good == 1, "R9 power-good kept", pwr_good, 1);
    @(negedge clk); vr_en = 0;
    @(negedge clk);
    check(dac_code == 0 && clk_en_n == 1 && pwr_good == 0, "R10 enable drop",
          dac_code, 0);
  endtask

  task automatic t_gpu();
    longint tx;
    int seen_hold;
    gpu_mode = 1; lp_sel = 1; vid = 7'd0;
    nclk(2); vr_en = 1;
    ramp_to(exp_vid(0), 20, 1000, "R6 GPU fast ramp R7 code 0", tx);
    check(clk_en_n == 1, "R3 no clock enable before qualification", clk_en_n, 1);
    for (int i = 0; i < 13; i++) pulse(1);
    check(clk_en_n == 0 && dac_code == 3000, "R3 GPU qualification", dac_code, 3000);
    @(negedge clk); vr_en = 0; nclk(2);
    lp_sel = 0; vid = 7'd40; vr_en = 1;
    ramp_to(exp_vid(40), 10, 1200, "R6 GPU normal ramp", tx);
    seen_hold = 0;
    for (int i = 0; i < 13; i++) pulse(1);
    check(clk_en_n == 0, "R3 GPU clock enable", clk_en_n, 0);
    vid = 7'd127;
    ramp_to(0, 10, 1200, "R7 VID clamp to zero", tx);
    nclk(20);
    check(dac_code == 0 && seen_hold == 0, "R7 clamp holds", dac_code, 0);
    @(negedge clk); por_ok = 0;
    @(negedge clk);
    check(dac_code == 0 && clk_en_n == 1 && pwr_good == 0, "R10 POR drop", clk_en_n, 1);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    nclk(4); rst_n = 1; nclk(2);
    t_reset();
    t_en_gate();
    t_cpu();
    t_gpu();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule